// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a timer with one up/down counter shared by several pulse-width outputs. The counter climbs from zero to a programmable turn value. It then runs back down to zero and climbs again. One full waveform period therefore lasts twice the turn value. Each output is driven by a private state bit. That bit is set to its active level when the counter meets the channel's threshold while descending. It is cleared when the counter meets the threshold while ascending. Between those events the bit keeps its level. The result is a pulse centred on the moment the count passes through zero.

Software uses one write port. Address 0 holds the turn value, and addresses 1 to N_CH hold the channel thresholds. Every written value goes into a holding register first. The holding registers move into the live registers together on the count step from turn−1 to turn, which is the start of a period, so a waveform never changes mid-period. A single enable input gates the counter clock. Reset puts the counter at zero, which is the middle of a period. A threshold with its top bit set is a request for 0% duty and forces the output inactive. A threshold of zero instead waits for the zero count before it goes inactive.

Top module: `cpwm_timer`

## Requirements
- R1: On an enabled cycle the counter steps up by one while ascending and down by one while descending. It turns to descending when it reaches the live turn value M, and turns to ascending when it reaches zero. The count shown equal to M recurs every 2·M cycles. A turn value of zero holds the counter at zero.
- R2: After synchronous active-low reset, the counter is 0 and ascending. The turn value, all thresholds and all state bits are 0, so each output equals its invert input.
- R3: When the shown count equals a channel's live threshold on an enabled cycle, the state bit becomes 1 on the next cycle if the counter is descending, and 0 if it is ascending. Each output is its state bit XOR its invert input.
- R4: A state bit keeps its level on every cycle without a match. This includes cycles after a threshold change, such as a threshold above M that never matches.
- R5: A threshold equal to M keeps the output active for the whole period once it has been set.
- R6: A threshold equal to M−1 makes the output inactive for exactly 2 cycles in each 2·M-cycle period.
- R7: A threshold with its top bit set forces the state bit to 0 on the next enabled cycle, and keeps it there for the whole period.
- R8: A threshold of 0 clears the state bit only when the count reaches zero while ascending. An active output therefore stays active through the descending half.
- R9: Writes go to holding registers. They become live together on the enabled step from M−1 to M, or on any enabled cycle while the live M is 0. A write made in that same cycle waits for the next boundary.
- R10: With the enable low, the counter, its direction and every state bit hold their values.
- R11: Write address 0 selects the turn value and address k+1 selects channel k. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 is the turn value, k+1 is channel k |
| wr_data | input | WIDTH | Write data |
| ch_inv | input | N_CH | Per-channel output inversion |
| cnt_val | output | WIDTH | Current count |
| cnt_down | output | 1 | 1 while the counter is descending |
| pwm_out | output | N_CH | Channel outputs |

## Verification
The hardest case to reach is the difference between a zero threshold and a negative one. That difference only shows when the state bit is already active at the moment the new threshold goes live. The stimulus first runs a channel at 100% duty (threshold equal to M) for a full period. It then queues the zero or negative threshold, waits for the turnaround that loads it, and samples the output one count below M on the way down. At that point a zero threshold still shows the output active, and a negative threshold already shows it inactive. A reference model follows the same writes and is compared against the outputs on every cycle.

// File: rtl/cpwm_pkg.sv
// Shared types for the center-aligned PWM timer.
package cpwm_pkg;
    // Counting direction of the shared up/down counter.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cpwm_dir_e;
endpackage

// File: rtl/cpwm_counter.sv
// Up/down counter with a double-buffered turn value.
// Counts 0..M..0, and the live M is reloaded from the holding register at
// the M-1 -> M step. Assumes the synchronous active-low reset has been
// applied before cnt_en is raised.
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mod_we,
    input  logic [WIDTH-1:0] mod_wdata,
    output logic [WIDTH-1:0] cnt,
    output cpwm_dir_e        dir,
    output logic             load
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] mod_buf;
    logic [WIDTH-1:0] mod_act;

    // Period boundary: the step that reaches the turn value, or idle at M = 0.
    assign load = tick_en && (dir == DIR_UP) &&
                  ((mod_act == '0) || ((cnt + ONE) == mod_act));

    // Holding register for software writes of the turn value.
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_buf <= '0;
        else if (mod_we) mod_buf <= mod_wdata;
    end

    // Live turn value, updated only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    mod_act <= '0;
        else if (load) mod_act <= mod_buf;
    end

    // Count and direction; the direction reverses at M and at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (tick_en) begin
            if (dir == DIR_UP) begin
                if (mod_act != '0) begin
                    cnt <= cnt + ONE;
                    if ((cnt + ONE) == mod_act) dir <= DIR_DOWN;
                end
            end else begin
                cnt <= cnt - ONE;
                if (cnt == ONE) dir <= DIR_UP;
            end
        end
    end

    // R1: while ascending the count is below M (or parked at zero).
    p_up_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_UP) |-> ((cnt < mod_act) || (cnt == '0)));

    // R1: a descending counter never shows zero.
    p_down_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_DOWN) |-> (cnt != '0));

    // R1: an enabled ascending step with non-zero M adds one.
    p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && dir == DIR_UP && mod_act != '0) |=> (cnt == $past(cnt) + ONE));

    // R10: nothing moves while the enable is low.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt) && $stable(dir)));

    // R9: the live turn value changes only at a boundary.
    p_mod_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mod_act));
endmodule

// File: rtl/cpwm_channel.sv
// One PWM channel: a double-buffered threshold and a sticky state bit.
// The bit is set on a descending match and cleared on an ascending match.
// A negative threshold forces it to 0. Assumes cnt/dir come from
// cpwm_counter on the same clock.
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic             cmp_we,
    input  logic [WIDTH-1:0] cmp_wdata,
    input  logic [WIDTH-1:0] cnt,
    input  cpwm_dir_e        dir,
    input  logic             inv,
    output logic             pwm
);
    logic [WIDTH-1:0] cmp_buf;
    logic [WIDTH-1:0] cmp_act;
    logic             state_q;
    logic             neg;
    logic             hit;

    assign neg = cmp_act[WIDTH-1];
    assign hit = (cmp_act == cnt);

    // Holding register for software writes of the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_buf <= '0;
        else if (cmp_we) cmp_buf <= cmp_wdata;
    end

    // Live threshold, loaded together with the turn value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_act <= '0;
        else if (load) cmp_act <= cmp_buf;
    end

    // Sticky output state: changes only on a match or a 0% request.
    always_ff @(posedge clk) begin
        if (!rst_n)           state_q <= 1'b0;
        else if (tick_en) begin
            if (neg)          state_q <= 1'b0;
            else if (hit)     state_q <= (dir == DIR_DOWN);
        end
    end

    assign pwm = state_q ^ inv;

    // R7: a negative threshold leaves the state inactive.
    p_neg_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && neg) |=> !state_q);

    // R4: without a match the state keeps its level.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && (neg || hit)) |=> $stable(state_q));

    // R3: a descending match drives the state active.
    p_down_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !neg && hit && dir == DIR_DOWN) |=> state_q);

    // R9: the live threshold changes only at a boundary.
    p_cmp_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_act));
endmodule

// File: rtl/cpwm_timer.sv
// Top of the center-aligned PWM timer: the write decode, one shared
// counter and N_CH channels. Assumes wr_* are synchronous to clk.
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(N_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [N_CH-1:0]   ch_inv,
    output logic [WIDTH-1:0]  cnt_val,
    output logic              cnt_down,
    output logic [N_CH-1:0]   pwm_out
);
    cpwm_dir_e dir;
    logic      load;
    logic      mod_we;

    // Address 0 selects the turn value.
    assign mod_we   = wr_en && (wr_addr == ADDR_W'(0));
    assign cnt_down = (dir == DIR_DOWN);

    cpwm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (cnt_en),
        .mod_we    (mod_we),
        .mod_wdata (wr_data),
        .cnt       (cnt_val),
        .dir       (dir),
        .load      (load)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic ch_we;
        // Address g+1 selects channel g.
        assign ch_we = wr_en && (wr_addr == ADDR_W'(g + 1));

        cpwm_channel #(.WIDTH(WIDTH)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (cnt_en),
            .load      (load),
            .cmp_we    (ch_we),
            .cmp_wdata (wr_data),
            .cnt       (cnt_val),
            .dir       (dir),
            .inv       (ch_inv[g]),
            .pwm       (pwm_out[g])
        );
    end
endmodule

// File: tb/cpwm_timer_tb.sv
module cpwm_timer_tb;
    localparam int N  = 2;
    localparam int W  = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [N-1:0]  ch_inv = 2'b10;
    logic [W-1:0]  cnt_val;
    logic          cnt_down;
    logic [N-1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R2";

    always #5 clk = ~clk;

    cpwm_timer #(.N_CH(N), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ch_inv(ch_inv),
        .cnt_val(cnt_val), .cnt_down(cnt_down), .pwm_out(pwm_out)
    );

    // Behavioural reference model, stepped on the rising edge.
    int m_cnt, m_mod, m_modb;
    bit m_down;
    int m_cmp[N], m_cmpb[N];
    bit m_st[N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_mod = 0; m_modb = 0;
            for (int k = 0; k < N; k++) begin m_cmp[k] = 0; m_cmpb[k] = 0; m_st[k] = 0; end
        end else begin
            if (cnt_en) begin
                bit ld;
                for (int k = 0; k < N; k++) begin
                    if (m_cmp[k] >= 32768) m_st[k] = 0;
                    else if (m_cmp[k] == m_cnt) m_st[k] = m_down;
                end
                ld = !m_down && (m_mod == 0 || m_cnt + 1 == m_mod);
                if (!m_down) begin
                    if (m_mod != 0) begin
                        m_cnt++;
                        if (m_cnt == m_mod) m_down = 1;
                    end
                end else begin
                    m_cnt--;
                    if (m_cnt == 0) m_down = 0;
                end
                if (ld) begin
                    m_mod = m_modb;
                    for (int k = 0; k < N; k++) m_cmp[k] = m_cmpb[k];
                end
            end
            if (wr_en) begin
                if (wr_addr == 0) m_modb = int'(wr_data);
                else if (int'(wr_addr) <= N) m_cmpb[int'(wr_addr) - 1] = int'(wr_data);
            end
        end
    end

    function automatic logic [N-1:0] m_pwm();
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = m_st[k] ^ ch_inv[k];
        return r;
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (int'(cnt_val) != m_cnt || cnt_down != m_down || pwm_out != m_pwm()) begin
                n_bad++;
                $display("FAIL %s model: cnt=%0d down=%0d pwm=%b expected cnt=%0d down=%0d pwm=%b",
                         cur_req, cnt_val, cnt_down, pwm_out, m_cnt, m_down, m_pwm());
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_at(input int v, input bit dn);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (int'(cnt_val) == v && cnt_down == dn) return;
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycles between two successive displays of count == v.
    task automatic period(input int v, output int p);
        p = 0;
        wait_at(v, 1'b1);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            p++;
            if (int'(cnt_val) == v && cnt_down) return;
        end
    endtask

    // Counts the inactive cycles of channel k over n cycles.
    task automatic count_off(input int k, input int n, output int off);
        off = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[k] == ch_inv[k]) off++;
        end
    endtask

    initial begin
        int p, off;
        bit ref_b;
        cycles(3);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R2 cnt", int'(cnt_val), 0);
        check("R2 dir", int'(cnt_down), 0);
        check("R2 pwm", int'(pwm_out), 2);

        cur_req = "R9";
        wr(0, 8); wr(1, 3); wr(2, 5);
        cycles(4);
        check("R9 held before enable", int'(cnt_val), 0);
        cnt_en = 1'b1;
        cur_req = "R1/R3";
        period(8, p);
        check("R1 period M=8", p, 16);
        count_off(0, 16, off);
        check("R3 ch0 off cycles M=8 T=3", off, 10);

        cur_req = "R9";
        wait_at(3, 1'b1);
        wr(0, 6);
        wait_at(7, 1'b0);
        @(negedge clk);
        check("R9 old M still used", int'(cnt_val), 8);
        period(6, p);
        check("R9 new M period", p, 12);

        cur_req = "R10";
        wait_at(4, 1'b1);
        cnt_en = 1'b0;
        cycles(10);
        check("R10 cnt hold", int'(cnt_val), 4);
        check("R10 dir hold", int'(cnt_down), 1);
        cnt_en = 1'b1;

        cur_req = "R5/R6";
        wr(1, 6); wr(2, 5);
        cycles(30);
        count_off(0, 12, off);
        check("R5 T=M off cycles", off, 0);
        count_off(1, 12, off);
        check("R6 T=M-1 off cycles", off, 2);

        cur_req = "R8";
        wr(1, 0);
        wait_at(6, 1'b1);
        wait_at(5, 1'b1);
        check("R8 zero threshold still active", int'(pwm_out[0]), 1);
        wait_at(1, 1'b0);
        check("R8 cleared after zero", int'(pwm_out[0]), 0);

        cur_req = "R7";
        wr(1, 6);
        cycles(30);
        check("R7 pre active", int'(pwm_out[0]), 1);
        wr(1, 16'h8000);
        wait_at(6, 1'b1);
        wait_at(5, 1'b1);
        check("R7 negative inactive at once", int'(pwm_out[0]), 0);
        count_off(0, 12, off);
        check("R7 whole period off", off, 12);

        cur_req = "R4";
        wr(2, 20);
        wait_at(6, 1'b1);
        ref_b = pwm_out[1];
        count_off(1, 24, off);
        check("R4 sticky without match", off, ref_b == ch_inv[1] ? 24 : 0);

        cur_req = "R11";
        wr(3, 2);
        cycles(30);
        period(6, p);
        check("R11 bad address ignored", p, 12);

        cur_req = "R1";
        wr(0, 1);
        cycles(20);
        period(1, p);
        check("R1 period M=1", p, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule